// File: doc/BRIEF.md
# Interrupt Flag and Mask Unit

This block gathers seven single-cycle event pulses from neighbouring logic into sticky flag bits, gates them with a per-source mask, and drives one interrupt line toward the host. Software reaches three registers through a small synchronous register port: the flags, the mask and an output-form control. A flag is cleared by writing 1 to its bit. Writing 0 leaves the bit alone, so one write can clear any chosen subset.

A flag is set whether or not its source is masked. Software can therefore poll masked sources while the interrupt line stays quiet. The interrupt line has four forms, chosen by a two-bit field. It can be a level or a one-cycle pulse, and either form can be active high or active low. A pulse marks each source that newly becomes both flagged and unmasked.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset the flags read 0x00, the mask reads 0x7F, the control register reads 0x00 and `irq_out` is 0.
- R2: An event pulse on input bit i sets flag bit i on the next clock edge, and the bit stays set until software clears it. Bit map: 6 short-circuit clear, 5 jack, 4 short-circuit, 3 ramp-up done, 2 ramp-down done, 1 gain-up done, 0 gain-down done.
- R3: A write to the flag register (address 0) clears every flag whose write-data bit is 1 and leaves every flag whose bit is 0. Writing 0x7F clears all flags.
- R4: If an event for a bit arrives in the same cycle as a write-1 clear of that bit, the flag stays set. Other bits in the same write are still cleared.
- R5: A flag is set by its event even while its mask bit is 1.
- R6: The mask register (address 1) uses the flag bit layout. A mask bit of 1 keeps that source from affecting `irq_out`.
- R7: With control form 0, `irq_out` is high while any unmasked flag is set and low otherwise.
- R8: With control form 1, `irq_out` is low while any unmasked flag is set and high otherwise.
- R9: With control form 2, `irq_out` goes high for exactly one cycle each time a source becomes both flagged and unmasked. An event on a flag that is already set gives no pulse.
- R10: With control form 3, `irq_out` idles high and goes low for exactly one cycle under the same conditions as R9.
- R11: The control register (address 2) holds the form in bits 7:6. Its other bits read 0, bit 7 of the flag and mask registers reads 0, and address 3 reads 0x00.
- R12: `irq_out` reflects a flag one clock edge after the flag becomes set. An event therefore reaches `irq_out` on the second clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_pulse | input | 7 | Single-cycle event pulses, one per source |
| reg_addr | input | 2 | Register select: 0 flags, 1 mask, 2 control |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the addressed register |
| irq_out | output | 1 | Interrupt line in the selected form |

## Verification
The bench targets the collision of an event with a write-1 clear of the same bit. A design that gave the clear priority would lose that event, and the flag register would read back without it. It checks that masked sources still flag, which a design gating the flags with the mask would fail. It also samples the pulse forms on each cycle around an event. This catches a pulse held longer than one cycle, a pulse missing for a second source, and a pulse repeated for a bit that was already set. Reads of the unused control bits and of address 3 catch a read mux that leaks stored or stale bits.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Output form of the interrupt line; bit 1 selects pulse, bit 0 selects low polarity
  typedef enum logic [1:0] {
    FORM_LEVEL_HI = 2'd0,
    FORM_LEVEL_LO = 2'd1,
    FORM_PULSE_HI = 2'd2,
    FORM_PULSE_LO = 2'd3
  } irq_form_e;

  localparam logic [1:0] ADDR_FLAGS = 2'd0;
  localparam logic [1:0] ADDR_MASK  = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int SRC_N    = 7,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int FORM_LSB = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [SRC_N-1:0]  flags,
  input  logic [SRC_N-1:0]  mask,
  input  irq_form_e         form,
  output logic [SRC_N-1:0]  flag_clr,
  output logic              mask_we,
  output logic [SRC_N-1:0]  mask_wdata,
  output logic              form_we,
  output irq_form_e         form_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  logic sel_flags, sel_mask, sel_ctrl;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    sel_flags = (reg_addr == ADDR_W'(ADDR_FLAGS));
    sel_mask  = (reg_addr == ADDR_W'(ADDR_MASK));
    sel_ctrl  = (reg_addr == ADDR_W'(ADDR_CTRL));
  end

  // Write strobes toward the storage blocks
  always_comb begin
    flag_clr   = (reg_wr && sel_flags) ? reg_wdata[SRC_N-1:0] : '0;
    mask_we    = reg_wr && sel_mask;
    mask_wdata = reg_wdata[SRC_N-1:0];
    form_we    = reg_wr && sel_ctrl;
    form_wdata = irq_form_e'(reg_wdata[FORM_LSB +: 2]);
  end

  // Read mux; unused bits and unused addresses return zero
  always_comb begin
    rd_next = '0;
    if (sel_flags)     rd_next[SRC_N-1:0]    = flags;
    else if (sel_mask) rd_next[SRC_N-1:0]    = mask;
    else if (sel_ctrl) rd_next[FORM_LSB +: 2] = form;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

endmodule

// File: rtl/evt_irq_flags.sv
module evt_irq_flags #(
  parameter int SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] evt_pulse,
  input  logic [SRC_N-1:0] flag_clr,
  output logic [SRC_N-1:0] flags
);

  // One sticky cell per source; a fresh event outranks a clear in the same cycle
  for (genvar i = 0; i < SRC_N; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)               flags[i] <= 1'b0;
      else if (evt_pulse[i]) flags[i] <= 1'b1;
      else if (flag_clr[i])  flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/evt_irq_cfg.sv
module evt_irq_cfg
  import evt_irq_pkg::*;
#(
  parameter int SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_we,
  input  logic [SRC_N-1:0] mask_wdata,
  input  logic             form_we,
  input  irq_form_e        form_wdata,
  output logic [SRC_N-1:0] mask,
  output irq_form_e        form
);

  localparam logic [SRC_N-1:0] MASK_RST = {SRC_N{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= MASK_RST;
      form <= FORM_LEVEL_HI;
    end else begin
      if (mask_we) mask <= mask_wdata;
      if (form_we) form <= form_wdata;
    end
  end

endmodule

// File: rtl/evt_irq_former.sv
module evt_irq_former
  import evt_irq_pkg::*;
#(
  parameter int SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] flags,
  input  logic [SRC_N-1:0] mask,
  input  irq_form_e        form,
  output logic             irq_out
);

  logic [SRC_N-1:0] live, live_prev;
  logic pending, fresh, asserted;

  always_comb begin
    live    = flags & ~mask;
    pending = |live;
    fresh   = |(live & ~live_prev);
    unique case (form)
      FORM_LEVEL_HI, FORM_LEVEL_LO: asserted = pending;
      default:                      asserted = fresh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_prev <= '0;
      irq_out   <= 1'b0;
    end else begin
      live_prev <= live;
      irq_out   <= asserted ^ form[0];
    end
  end

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int SRC_N    = 7,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int FORM_LSB = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  evt_pulse,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);

  logic [SRC_N-1:0] flag_q, mask_q, flag_clr, mask_wdata;
  logic             mask_we, form_we;
  irq_form_e        form_q, form_wdata;

  evt_irq_decode #(
    .SRC_N(SRC_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FORM_LSB(FORM_LSB)
  ) u_decode (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .flags(flag_q), .mask(mask_q), .form(form_q),
    .flag_clr(flag_clr), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .form_we(form_we), .form_wdata(form_wdata), .reg_rdata(reg_rdata)
  );

  evt_irq_flags #(.SRC_N(SRC_N)) u_flags (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .flag_clr(flag_clr), .flags(flag_q)
  );

  evt_irq_cfg #(.SRC_N(SRC_N)) u_cfg (
    .clk(clk), .rst(rst),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .form_we(form_we), .form_wdata(form_wdata),
    .mask(mask_q), .form(form_q)
  );

  evt_irq_former #(.SRC_N(SRC_N)) u_former (
    .clk(clk), .rst(rst), .flags(flag_q), .mask(mask_q), .form(form_q), .irq_out(irq_out)
  );

endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk #(
  parameter int SRC_N  = 7,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [SRC_N-1:0]  evt,
  input logic [ADDR_W-1:0] addr,
  input logic              wr,
  input logic [SRC_N-1:0]  wbits,
  input logic [SRC_N-1:0]  flags,
  input logic [SRC_N-1:0]  mask,
  input logic [1:0]        form,
  input logic              irq
);

  logic wr_flags, live_any;
  always_comb begin
    wr_flags = wr && (addr == '0);
    live_any = (flags & ~mask) != '0;
  end

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_flags |=> ((flags & $past(flags)) == $past(flags)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_flags && evt == '0) |=> ((flags & $past(wbits)) == '0));

  p_evt_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_flags && (evt & wbits) != '0) |=> ((flags & $past(evt & wbits)) == $past(evt & wbits)));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (form == 2'd0 && !live_any) |=> !irq);

  p_level_hi_r7: assert property (@(posedge clk) disable iff (rst)
    (form == 2'd0 && live_any) |=> irq);

  p_level_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (form == 2'd1) |=> (irq == !$past(live_any)));

  p_pulse_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (form == 2'd2 && !live_any) |=> !irq);

  p_pulse_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (form == 2'd3 && !live_any) |=> irq);

endmodule

bind evt_irq_unit evt_irq_unit_chk #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .evt(evt_pulse), .addr(reg_addr), .wr(reg_wr),
  .wbits(reg_wdata[SRC_N-1:0]), .flags(flag_q), .mask(mask_q), .form(form_q), .irq(irq_out)
);

// File: tb/evt_irq_unit_bench.sv
module evt_irq_unit_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] evt_pulse = '0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  evt_irq_unit u_evt_irq_unit (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // Vector: kind[23:22] (0 event, 1 write, 2 read, 3 irq), addr[21:20], data[19:12], expect[11:4], req[3:0]
  localparam int NV = 34;
  localparam logic [23:0] VECS [0:NV-1] = '{
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd1},   // R1 flags
    {2'd2, 2'd1, 8'h00, 8'h7F, 4'd1},   // R1 mask
    {2'd2, 2'd2, 8'h00, 8'h00, 4'd1},   // R1 control
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd1},   // R1 irq
    {2'd0, 2'd0, 8'h28, 8'h00, 4'd2},   // R2 jack + ramp-up
    {2'd2, 2'd0, 8'h00, 8'h28, 4'd5},   // R5 set while masked
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd6},   // R6 masked -> quiet
    {2'd1, 2'd1, 8'h57, 8'h00, 4'd6},   // unmask bits 5,3
    {2'd3, 2'd0, 8'h00, 8'h01, 4'd7},   // R7 level high
    {2'd1, 2'd0, 8'h08, 8'h00, 4'd3},
    {2'd2, 2'd0, 8'h00, 8'h20, 4'd3},   // R3 partial clear
    {2'd3, 2'd0, 8'h00, 8'h01, 4'd7},
    {2'd1, 2'd0, 8'h20, 8'h00, 4'd3},
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd7},   // R7 drops
    {2'd0, 2'd0, 8'h03, 8'h00, 4'd2},
    {2'd2, 2'd0, 8'h00, 8'h03, 4'd2},   // R2 gain flags
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd6},   // R6
    {2'd1, 2'd0, 8'h02, 8'h00, 4'd3},
    {2'd2, 2'd0, 8'h00, 8'h01, 4'd3},   // R3 zero bits untouched
    {2'd1, 2'd2, 8'hFF, 8'h00, 4'd11},
    {2'd2, 2'd2, 8'h00, 8'hC0, 4'd11},  // R11 only form bits
    {2'd2, 2'd3, 8'h00, 8'h00, 4'd11},  // R11 unused address
    {2'd1, 2'd2, 8'h40, 8'h00, 4'd8},
    {2'd3, 2'd0, 8'h00, 8'h01, 4'd8},   // R8 idle high
    {2'd0, 2'd0, 8'h20, 8'h00, 4'd8},
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd8},   // R8 asserted low
    {2'd1, 2'd0, 8'h7F, 8'h00, 4'd3},
    {2'd2, 2'd0, 8'h00, 8'h00, 4'd3},   // R3 clear all
    {2'd3, 2'd0, 8'h00, 8'h01, 4'd8},
    {2'd1, 2'd2, 8'h00, 8'h00, 4'd7},
    {2'd3, 2'd0, 8'h00, 8'h00, 4'd7},
    {2'd1, 2'd1, 8'h7F, 8'h00, 4'd6},
    {2'd2, 2'd1, 8'h00, 8'h7F, 4'd6}    // R6 mask readback
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_event(input logic [6:0] e);
    @(negedge clk) evt_pulse = e;
    @(negedge clk) evt_pulse = '0;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk) reg_addr = a;
    @(negedge clk);
    @(negedge clk) d = reg_rdata;
  endtask

  task automatic settle_irq(output logic v);
    @(negedge clk);
    @(negedge clk) v = irq_out;
  endtask

  // Event presented across one edge, irq sampled after edges 1, 2 and 3
  task automatic pulse_probe(input logic [6:0] e, input logic a1, input logic a2,
                             input logic a3, input string tag);
    do_event(e);
    check(tag, {7'd0, irq_out}, {7'd0, a1});
    @(negedge clk) check(tag, {7'd0, irq_out}, {7'd0, a2});
    @(negedge clk) check(tag, {7'd0, irq_out}, {7'd0, a3});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic       iv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [23:0] v;
      string tag;
      v = VECS[k];
      tag = $sformatf("R%0d vec%0d", v[3:0], k);
      case (v[23:22])
        2'd0: do_event(v[18:12]);
        2'd1: do_write(v[21:20], v[19:12]);
        2'd2: begin do_read(v[21:20], rd); check(tag, rd, v[11:4]); end
        default: begin settle_irq(iv); check(tag, {7'd0, iv}, v[11:4]); end
      endcase
    end

    // R4: event meets a clear of the same bit; the other cleared bit goes
    do_event(7'h03);
    @(negedge clk) begin
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h03; evt_pulse = 7'h01;
    end
    @(negedge clk) begin reg_wr = 1'b0; evt_pulse = '0; end
    do_read(2'd0, rd);
    check("R4 event beats clear", rd, 8'h01);
    do_write(2'd0, 8'h7F);

    // R12: level form, irq one edge after the flag
    do_write(2'd1, 8'h00);
    repeat (2) @(negedge clk);
    pulse_probe(7'h04, 1'b0, 1'b1, 1'b1, "R12 level latency");
    do_write(2'd0, 8'h7F);
    settle_irq(iv);
    check("R7 cleared", {7'd0, iv}, 8'h00);

    // R9: active-high pulse
    do_write(2'd2, 8'h80);
    settle_irq(iv);
    check("R9 idle", {7'd0, iv}, 8'h00);
    pulse_probe(7'h02, 1'b0, 1'b1, 1'b0, "R9 pulse gain-up");
    pulse_probe(7'h10, 1'b0, 1'b1, 1'b0, "R9 pulse second source");
    pulse_probe(7'h02, 1'b0, 1'b0, 1'b0, "R9 no pulse when already set");

    // R10: active-low pulse
    do_write(2'd0, 8'h7F);
    do_write(2'd2, 8'hC0);
    settle_irq(iv);
    check("R10 idle high", {7'd0, iv}, 8'h01);
    pulse_probe(7'h40, 1'b1, 1'b0, 1'b1, "R10 low pulse");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule